// File: doc/BRIEF.md
# Termination Regulator Mode and Fault-Retry Sequencer

This block is the digital state controller that sits beside a tracking termination regulator. It turns two active-low power-state requests (a deep-off request and a suspend request) into enables for the regulated output, the reference output and the output discharge path. It also issues a soft-start request whenever the regulated output is brought up, and it drives an active-low power-good that the host reads. The two request pins are asynchronous to the controller clock. They pass through multi-flop synchronizers before the state machine sees them.

Fault handling follows three policies. A short-circuit flag trips the output at once. A current-limit flag trips it only if the flag is still present when a dwell timer expires. An over-temperature flag shuts both outputs off until a separate cool-down flag is seen. Every trip is followed by a fixed wait and then a new soft start. Out-of-window conditions only release power-good and never stop regulation. All timers count a prescaled tick, and every duration is a parameter.

Top module: `ddr_term_supervisor`

## Requirements
- R1: At reset, and on any cycle after `supply_ok` is low, all enables are 0 and `pgood_n` is 1. A low supply overrides every other input.
- R2: When the synchronized `shdn_n` is low and the supply is good, the controller discharges (`dis_en`=1), turns both outputs off and releases `pgood_n`, whatever `stby_n` is.
- R3: When `shdn_n` is high and `stby_n` is low, the regulated output is off, the reference output stays on, discharge is off and `pgood_n` is 1.
- R4: `dis_en` is 1 only in the shutdown state. It is never 1 together with either output enable or with `ss_req`.
- R5: Every rise of `reg_en` comes with `ss_req`=1. `ss_req` stays 1 until `ss_done` is seen, after which the controller enters regulation.
- R6: `pgood_n` goes low only in regulation, and only after `in_window` has been 1 for `PG_TICKS` ticks since regulation began.
- R7: An `ilim_flag` pulse shorter than `OC_TICKS` ticks has no effect. If the flag is held for `OC_TICKS` ticks, the controller turns the regulated output off, keeps the reference on and releases `pgood_n`.
- R8: `short_flag` turns the regulated output off on the next clock edge, with no timer. The reference stays on.
- R9: After a current-limit or short-circuit trip, the controller waits `RETRY_TICKS` ticks and then raises `ss_req` for a new soft start.
- R10: `overtemp_flag` turns both outputs off and releases `pgood_n`. The controller stays off until `temp_cool_flag` is 1 and `overtemp_flag` is 0, then waits `RETRY_TICKS` ticks with both outputs still off, then soft-starts.
- R11: In regulation, `in_window`=0 releases `pgood_n` one cycle later while `reg_en` stays 1. Once the delay of R6 has elapsed, a return of `in_window` pulls `pgood_n` low one cycle later with no new delay.
- R12: `shdn_n` and `stby_n` reach the state machine through `SYNC_STAGES` flops, so a change has no effect on the outputs in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Asynchronous deep-off request, active low |
| stby_n | input | 1 | Asynchronous suspend request, active low |
| supply_ok | input | 1 | Input supply within operating range |
| ilim_flag | input | 1 | Output current above the limit |
| short_flag | input | 1 | Output current above the short-circuit level |
| overtemp_flag | input | 1 | Die temperature above the trip point |
| temp_cool_flag | input | 1 | Die temperature back below trip minus hysteresis |
| in_window | input | 1 | Regulated output inside its voltage window |
| ss_done | input | 1 | Soft-start ramp finished |
| reg_en | output | 1 | Regulated output enable |
| ref_en | output | 1 | Reference output enable |
| dis_en | output | 1 | Output discharge enable |
| ss_req | output | 1 | Soft-start request |
| pgood_n | output | 1 | Power-good, active low |

## Verification
The hardest situation to reach is the thermal recovery path. It needs an over-temperature trip, a long period with the flag gone but no cool-down indication, and then a retry wait during which the reference must still stay off. The stimulus reaches it in three steps. It first lets the block settle in regulation with power-good asserted. It then drops the trip flag while holding the cool-down flag low for well over a retry period. Finally it raises the cool-down flag and samples once partway through the retry wait and once after it ends. The current-limit trip and the retry duration are measured in cycles against windows derived from the tick divider, because tick phase is not fixed relative to the stimulus.

// File: rtl/ddr_sup_pkg.sv
package ddr_sup_pkg;

  typedef enum int unsigned {
    IX_OFF     = 0,
    IX_SHDN    = 1,
    IX_STBY    = 2,
    IX_SOFT    = 3,
    IX_RUN     = 4,
    IX_RETRY   = 5,
    IX_HOT     = 6,
    IX_HOTWAIT = 7
  } st_ix_e;

  localparam int unsigned NUM_STATES = 8;

  typedef logic [NUM_STATES-1:0] st_vec_t;

  typedef struct packed {
    logic reg_en;
    logic ref_en;
    logic dis_en;
    logic ss_req;
  } drv_t;

  function automatic st_vec_t st_bit(input st_ix_e ix);
    st_bit = st_vec_t'(1) << ix;
  endfunction

endpackage

// File: rtl/ddr_sup_sync.sv
module ddr_sup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ddr_sup_tick.sv
module ddr_sup_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr_sup_timer.sv
module ddr_sup_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] END_CNT = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                cnt <= '0;
    else if (tick && cnt != END_CNT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == END_CNT);

endmodule

// File: rtl/ddr_term_supervisor.sv
module ddr_term_supervisor
  import ddr_sup_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int SYNC_STAGES = 2,
  parameter int OC_TICKS    = 10000,
  parameter int RETRY_TICKS = 100000,
  parameter int PG_TICKS    = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic shdn_n,
  input  logic stby_n,
  input  logic supply_ok,
  input  logic ilim_flag,
  input  logic short_flag,
  input  logic overtemp_flag,
  input  logic temp_cool_flag,
  input  logic in_window,
  input  logic ss_done,
  output logic reg_en,
  output logic ref_en,
  output logic dis_en,
  output logic ss_req,
  output logic pgood_n
);

  localparam int NUM_REQ = 2;
  localparam st_vec_t ST_OFF     = st_bit(IX_OFF);
  localparam st_vec_t ST_SHDN    = st_bit(IX_SHDN);
  localparam st_vec_t ST_STBY    = st_bit(IX_STBY);
  localparam st_vec_t ST_SOFT    = st_bit(IX_SOFT);
  localparam st_vec_t ST_RUN     = st_bit(IX_RUN);
  localparam st_vec_t ST_RETRY   = st_bit(IX_RETRY);
  localparam st_vec_t ST_HOT     = st_bit(IX_HOT);
  localparam st_vec_t ST_HOTWAIT = st_bit(IX_HOTWAIT);

  // request synchronizers: index 0 deep-off, index 1 suspend
  logic [NUM_REQ-1:0] req_raw;
  logic [NUM_REQ-1:0] req_s;
  logic sd_n_s;
  logic sb_n_s;

  assign req_raw = {stby_n, shdn_n};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_sync
    ddr_sup_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b0)
    ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (req_raw[g]),
      .q  (req_s[g])
    );
  end

  assign sd_n_s = req_s[0];
  assign sb_n_s = req_s[1];

  // shared time base
  logic tick;

  ddr_sup_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  st_vec_t st;
  st_vec_t nxt;

  logic oc_done;
  logic retry_done;
  logic pg_done;
  logic active;
  logic oc_clr;
  logic retry_clr;
  logic pg_clr;

  assign active    = st[IX_SOFT] | st[IX_RUN];
  assign oc_clr    = !ilim_flag || !active;
  assign retry_clr = !(st[IX_RETRY] | st[IX_HOTWAIT]);
  assign pg_clr    = !st[IX_RUN] || (!in_window && !pg_done);

  ddr_sup_timer #(.LIMIT(OC_TICKS)) u_oc_tmr (
    .clk  (clk),
    .rst  (rst),
    .clear(oc_clr),
    .tick (tick),
    .done (oc_done)
  );

  ddr_sup_timer #(.LIMIT(RETRY_TICKS)) u_retry_tmr (
    .clk  (clk),
    .rst  (rst),
    .clear(retry_clr),
    .tick (tick),
    .done (retry_done)
  );

  ddr_sup_timer #(.LIMIT(PG_TICKS)) u_pg_tmr (
    .clk  (clk),
    .rst  (rst),
    .clear(pg_clr),
    .tick (tick),
    .done (pg_done)
  );

  // next-state logic: supply, then deep-off, then suspend, then faults
  always_comb begin
    nxt = st;
    if (!supply_ok) begin
      nxt = ST_OFF;
    end else if (!sd_n_s) begin
      nxt = ST_SHDN;
    end else if (!sb_n_s) begin
      nxt = ST_STBY;
    end else if (st[IX_OFF] | st[IX_SHDN] | st[IX_STBY]) begin
      nxt = ST_SOFT;
    end else if (active) begin
      if (overtemp_flag)               nxt = ST_HOT;
      else if (short_flag)             nxt = ST_RETRY;
      else if (oc_done)                nxt = ST_RETRY;
      else if (st[IX_SOFT] && ss_done) nxt = ST_RUN;
    end else if (st[IX_RETRY]) begin
      if (overtemp_flag)   nxt = ST_HOT;
      else if (retry_done) nxt = ST_SOFT;
    end else if (st[IX_HOT]) begin
      if (!overtemp_flag && temp_cool_flag) nxt = ST_HOTWAIT;
    end else if (st[IX_HOTWAIT]) begin
      if (overtemp_flag)   nxt = ST_HOT;
      else if (retry_done) nxt = ST_SOFT;
    end else begin
      nxt = ST_OFF;
    end
  end

  function automatic drv_t decode(input st_vec_t s);
    drv_t d;
    d.reg_en = s[IX_SOFT] | s[IX_RUN];
    d.ref_en = s[IX_SOFT] | s[IX_RUN] | s[IX_STBY] | s[IX_RETRY];
    d.dis_en = s[IX_SHDN];
    d.ss_req = s[IX_SOFT];
    return d;
  endfunction

  drv_t drv_nxt;
  assign drv_nxt = decode(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      reg_en  <= 1'b0;
      ref_en  <= 1'b0;
      dis_en  <= 1'b0;
      ss_req  <= 1'b0;
      pgood_n <= 1'b1;
    end else begin
      st      <= nxt;
      reg_en  <= drv_nxt.reg_en;
      ref_en  <= drv_nxt.ref_en;
      dis_en  <= drv_nxt.dis_en;
      ss_req  <= drv_nxt.ss_req;
      pgood_n <= !(nxt[IX_RUN] && pg_done && in_window);
    end
  end

endmodule

// File: rtl/ddr_sup_checker.sv
module ddr_sup_checker (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic short_flag,
  input logic in_window,
  input logic sd_s,
  input logic sb_s,
  input logic reg_en,
  input logic ref_en,
  input logic dis_en,
  input logic ss_req,
  input logic pgood_n
);

  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!reg_en && !ref_en && !dis_en && pgood_n)); // R1

  AST_SHDN_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !sd_s) |=> (dis_en && !reg_en && !ref_en && pgood_n)); // R2

  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && sd_s && !sb_s) |=> (!reg_en && ref_en && !dis_en && pgood_n)); // R3

  AST_DIS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    dis_en |-> (!reg_en && !ref_en && !ss_req)); // R4

  AST_SS_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_en) |-> ss_req); // R5

  AST_PG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !pgood_n |-> (reg_en && !ss_req && $past(in_window))); // R6

  AST_SHORT_TRIP: assert property (@(posedge clk) disable iff (rst)
    (reg_en && short_flag) |=> !reg_en); // R8

endmodule

bind ddr_term_supervisor ddr_sup_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .short_flag(short_flag),
  .in_window (in_window),
  .sd_s      (sd_n_s),
  .sb_s      (sb_n_s),
  .reg_en    (reg_en),
  .ref_en    (ref_en),
  .dis_en    (dis_en),
  .ss_req    (ss_req),
  .pgood_n   (pgood_n)
);

// File: tb/ddr_term_supervisor_test.sv
module ddr_term_supervisor_test;

  logic clk = 1'b0;
  logic rst;
  logic shdn_n, stby_n, supply_ok, ilim_flag, short_flag;
  logic overtemp_flag, temp_cool_flag, in_window, ss_done;
  logic reg_en, ref_en, dis_en, ss_req, pgood_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr_term_supervisor #(
    .TICK_DIV   (4),
    .SYNC_STAGES(2),
    .OC_TICKS   (10),
    .RETRY_TICKS(20),
    .PG_TICKS   (8)
  ) uut (
    .clk           (clk),
    .rst           (rst),
    .shdn_n        (shdn_n),
    .stby_n        (stby_n),
    .supply_ok     (supply_ok),
    .ilim_flag     (ilim_flag),
    .short_flag    (short_flag),
    .overtemp_flag (overtemp_flag),
    .temp_cool_flag(temp_cool_flag),
    .in_window     (in_window),
    .ss_done       (ss_done),
    .reg_en        (reg_en),
    .ref_en        (ref_en),
    .dis_en        (dis_en),
    .ss_req        (ss_req),
    .pgood_n       (pgood_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_in(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset;
    rst = 1'b1; supply_ok = 1'b0; shdn_n = 1'b1; stby_n = 1'b1;
    ilim_flag = 1'b0; short_flag = 1'b0; overtemp_flag = 1'b0;
    temp_cool_flag = 1'b0; in_window = 1'b0; ss_done = 1'b0;
    cyc(4);
    chk("R1", "reset reg_en", reg_en, 1'b0);
    chk("R1", "reset ref_en", ref_en, 1'b0);
    chk("R1", "reset dis_en", dis_en, 1'b0);
    chk("R1", "reset pgood_n", pgood_n, 1'b1);
    rst = 1'b0;
    cyc(10);
    chk("R1", "low supply ref_en", ref_en, 1'b0);
    chk("R1", "low supply dis_en", dis_en, 1'b0);
  endtask

  task automatic t_startup;
    supply_ok = 1'b1;
    cyc(1);
    chk("R5", "start reg_en", reg_en, 1'b1);
    chk("R5", "start ss_req", ss_req, 1'b1);
    cyc(5);
    chk("R5", "ss_req held", ss_req, 1'b1);
    in_window = 1'b1; ss_done = 1'b1;
    cyc(1);
    chk("R5", "ss_req drop", ss_req, 1'b0);
    cyc(20);
    chk("R6", "pg still released", pgood_n, 1'b1);
    cyc(25);
    chk("R6", "pg asserted", pgood_n, 1'b0);
  endtask

  task automatic t_window;
    in_window = 1'b0;
    cyc(1);
    chk("R11", "pg released", pgood_n, 1'b1);
    chk("R11", "reg_en kept", reg_en, 1'b1);
    cyc(10);
    chk("R11", "pg stays released", pgood_n, 1'b1);
    in_window = 1'b1;
    cyc(1);
    chk("R11", "pg back at once", pgood_n, 1'b0);
  endtask

  task automatic t_oc_glitch;
    ilim_flag = 1'b1;
    cyc(20);
    ilim_flag = 1'b0;
    cyc(60);
    chk("R7", "short ilim reg_en", reg_en, 1'b1);
    chk("R7", "short ilim pg", pgood_n, 1'b0);
  endtask

  task automatic measure_restart(input string req);
    int m = 0;
    while (ss_req !== 1'b1 && m < 300) begin
      cyc(1);
      m++;
    end
    chk_in(req, "retry wait cycles", m, 74, 86);
  endtask

  task automatic t_oc_trip;
    int n = 0;
    ss_done = 1'b0;
    ilim_flag = 1'b1;
    while (reg_en === 1'b1 && n < 200) begin
      cyc(1);
      n++;
    end
    chk_in("R7", "ilim trip cycles", n, 36, 46);
    chk("R7", "trip ref_en", ref_en, 1'b1);
    chk("R7", "trip pg", pgood_n, 1'b1);
    ilim_flag = 1'b0;
    measure_restart("R9");
    ss_done = 1'b1;
    cyc(50);
    chk("R9", "back in regulation pg", pgood_n, 1'b0);
  endtask

  task automatic t_short;
    ss_done = 1'b0;
    short_flag = 1'b1;
    cyc(1);
    short_flag = 1'b0;
    chk("R8", "short reg_en", reg_en, 1'b0);
    chk("R8", "short ref_en", ref_en, 1'b1);
    measure_restart("R9");
    ss_done = 1'b1;
    cyc(50);
    chk("R8", "recovered pg", pgood_n, 1'b0);
  endtask

  task automatic t_thermal;
    ss_done = 1'b0;
    overtemp_flag = 1'b1;
    cyc(1);
    chk("R10", "hot reg_en", reg_en, 1'b0);
    chk("R10", "hot ref_en", ref_en, 1'b0);
    chk("R10", "hot pg", pgood_n, 1'b1);
    chk("R4", "hot dis_en", dis_en, 1'b0);
    overtemp_flag = 1'b0;
    cyc(150);
    chk("R10", "awaiting cool ref_en", ref_en, 1'b0);
    chk("R10", "awaiting cool reg_en", reg_en, 1'b0);
    temp_cool_flag = 1'b1;
    cyc(50);
    chk("R10", "cool retry ref_en", ref_en, 1'b0);
    chk("R10", "cool retry ss_req", ss_req, 1'b0);
    cyc(40);
    chk("R10", "thermal restart ss_req", ss_req, 1'b1);
    temp_cool_flag = 1'b0;
    ss_done = 1'b1;
    cyc(50);
    chk("R10", "thermal recovered pg", pgood_n, 1'b0);
  endtask

  task automatic t_standby;
    ss_done = 1'b0;
    stby_n = 1'b0;
    cyc(1);
    chk("R12", "no effect before sync", reg_en, 1'b1);
    cyc(3);
    chk("R3", "standby reg_en", reg_en, 1'b0);
    chk("R3", "standby ref_en", ref_en, 1'b1);
    chk("R3", "standby pg", pgood_n, 1'b1);
    chk("R4", "standby dis_en", dis_en, 1'b0);
    stby_n = 1'b1;
    cyc(4);
    chk("R5", "standby exit ss_req", ss_req, 1'b1);
    ss_done = 1'b1;
    cyc(45);
    chk("R6", "post standby pg", pgood_n, 1'b0);
  endtask

  task automatic t_shutdown;
    ss_done = 1'b0;
    stby_n = 1'b0; shdn_n = 1'b0;
    cyc(4);
    chk("R2", "shdn dis_en", dis_en, 1'b1);
    chk("R2", "shdn ref_en", ref_en, 1'b0);
    chk("R2", "shdn reg_en", reg_en, 1'b0);
    chk("R2", "shdn pg", pgood_n, 1'b1);
    stby_n = 1'b1;
    cyc(4);
    chk("R2", "shdn over stby released", dis_en, 1'b1);
    shdn_n = 1'b1;
    cyc(4);
    chk("R4", "exit dis_en", dis_en, 1'b0);
    chk("R5", "exit ss_req", ss_req, 1'b1);
  endtask

  task automatic t_supply_drop;
    supply_ok = 1'b0;
    cyc(1);
    chk("R1", "drop reg_en", reg_en, 1'b0);
    chk("R1", "drop ref_en", ref_en, 1'b0);
    chk("R1", "drop pg", pgood_n, 1'b1);
  endtask

  initial begin
    t_reset;
    t_startup;
    t_window;
    t_oc_glitch;
    t_oc_trip;
    t_short;
    t_thermal;
    t_standby;
    t_shutdown;
    t_supply_drop;
    finished = 1'b1;
    report;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
      $finish;
    end
  end

endmodule